// File: doc/BRIEF.md
# Sectioned Two-Way Latching Bus Transceiver

This block passes data between two buses, side A and side B, through two separate banks of level-sensitive storage, one for each direction. The datapath is split into equal sections. Each section has its own set of six active-low controls, three per direction: a chip select, a latch gate and a drive enable. Several sections can run as narrow independent transceivers, or be driven from common controls to act as one wide path.

Within one direction of one section, the chip select must be low both to load storage and to drive the far side. When the chip select and the latch gate are both low, the storage is transparent and the far-side output follows the near-side input in the same cycle. When the latch gate goes high, the storage holds the value it last captured. The far side is driven only while the chip select and the drive enable are both low. The high-impedance state is shown by a per-bit enable vector beside each output data bus. A per-section flag reports when both directions drive at once.

Storage is built as clocked registers that capture on every rising clock edge while the gate is open, plus a bypass mux that gives transparency within the cycle. The controls and data are plain synchronous pins. There is no valid/ready handshake, because the block has no flow control and never applies back-pressure.

Top module: `latched_bus_xcvr`

## Requirements
- R1: After reset, both storage banks of every section hold zero. With the chip select low, the latch gate high and the drive enable low, the driven outputs read zero.
- R2: While a direction's chip select and latch gate are both low in a section, its storage is transparent. When that direction is also driving, the far-side output equals the near-side input in the same cycle.
- R3: After the latch gate goes high, the far-side output shows the near-side value present at the last rising clock edge at which the gate was open. Later near-side changes have no effect.
- R4: While the chip select is high, storage is not loaded, whatever the latch gate does. A later read with the gate closed returns the value stored before.
- R5: A direction drives its far-side bits, with every enable bit of the section at 1, only when its chip select and drive enable are both low. Otherwise every enable bit of that section is 0.
- R6: Any output data bit whose enable bit is 0 reads 0.
- R7: The B-to-A direction behaves as in R2 to R6, using its own controls, the B input and the A output. It has storage separate from the A-to-B direction.
- R8: Section k uses bits [k*SEC_W +: SEC_W] of every data bus and bit k of every control vector. One section's controls never change another section's storage or outputs.
- R9: The contention bit of a section is 1 exactly when both of its directions drive at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; storage captures on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; clears all storage |
| a_in | input | SEC_W*NUM_SEC | Data arriving from side A |
| b_in | input | SEC_W*NUM_SEC | Data arriving from side B |
| ce_ab_n | input | NUM_SEC | A-to-B chip select, active low, one bit per section |
| le_ab_n | input | NUM_SEC | A-to-B latch gate, low means transparent |
| oe_ab_n | input | NUM_SEC | A-to-B drive enable, active low |
| ce_ba_n | input | NUM_SEC | B-to-A chip select, active low |
| le_ba_n | input | NUM_SEC | B-to-A latch gate, low means transparent |
| oe_ba_n | input | NUM_SEC | B-to-A drive enable, active low |
| b_out | output | SEC_W*NUM_SEC | Data driven onto side B |
| b_oe | output | SEC_W*NUM_SEC | Per-bit drive enable for side B; 0 means high impedance |
| a_out | output | SEC_W*NUM_SEC | Data driven onto side A |
| a_oe | output | SEC_W*NUM_SEC | Per-bit drive enable for side A; 0 means high impedance |
| contention | output | NUM_SEC | Per-section flag: both directions drive at once |

## Verification
The bench builds the block with SEC_W=4 and NUM_SEC=2. Each section then has six control bits, and the twelve control bits of both sections give 4096 combinations, so a full sweep of them fits in a short run. The sweep runs twice with different data patterns. This covers every transition between gate states and every overlap of drive between directions and sections. Expected outputs come from an arithmetic storage model that the bench updates at each rising edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Active-low control triple for one direction of one section
  typedef struct packed {
    logic ce_n;
    logic le_n;
    logic oe_n;
  } dir_ctl_t;

  // Storage is transparent when chip select and gate are both low
  function automatic logic gate_open(dir_ctl_t c);
    return !c.ce_n && !c.le_n;
  endfunction

  // Far side is driven when chip select and drive enable are both low
  function automatic logic drive_on(dir_ctl_t c);
    return !c.ce_n && !c.oe_n;
  endfunction

endpackage

// File: rtl/xcvr_latch_bank.sv
module xcvr_latch_bank
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  dir_ctl_t     ctl,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] doe,
  output logic         driving
);

  logic [W-1:0] held_q;
  logic [W-1:0] view;
  logic         open_w;

  assign open_w  = gate_open(ctl);
  assign driving = drive_on(ctl);

  // Level storage modelled as capture on every edge while the gate is open
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_q <= '0;
    else if (open_w) held_q <= din;
  end

  // Bypass gives transparency within the cycle
  assign view = open_w ? din : held_q;
  assign dout = driving ? view : '0;
  assign doe  = {W{driving}};

endmodule

// File: rtl/xcvr_section.sv
module xcvr_section
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  dir_ctl_t     ab_ctl,
  input  dir_ctl_t     ba_ctl,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  output logic         clash
);

  logic ab_drv, ba_drv;

  xcvr_latch_bank #(.W(W)) u_ab (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ab_ctl),
    .din     (a_in),
    .dout    (b_out),
    .doe     (b_oe),
    .driving (ab_drv)
  );

  xcvr_latch_bank #(.W(W)) u_ba (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ba_ctl),
    .din     (b_in),
    .dout    (a_out),
    .doe     (a_oe),
    .driving (ba_drv)
  );

  assign clash = ab_drv && ba_drv;

endmodule

// File: rtl/latched_bus_xcvr.sv
module latched_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int SEC_W   = 18,
  parameter int NUM_SEC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SEC_W*NUM_SEC-1:0] a_in,
  input  logic [SEC_W*NUM_SEC-1:0] b_in,
  input  logic [NUM_SEC-1:0]       ce_ab_n,
  input  logic [NUM_SEC-1:0]       le_ab_n,
  input  logic [NUM_SEC-1:0]       oe_ab_n,
  input  logic [NUM_SEC-1:0]       ce_ba_n,
  input  logic [NUM_SEC-1:0]       le_ba_n,
  input  logic [NUM_SEC-1:0]       oe_ba_n,
  output logic [SEC_W*NUM_SEC-1:0] b_out,
  output logic [SEC_W*NUM_SEC-1:0] b_oe,
  output logic [SEC_W*NUM_SEC-1:0] a_out,
  output logic [SEC_W*NUM_SEC-1:0] a_oe,
  output logic [NUM_SEC-1:0]       contention
);

  localparam int TOT_W = SEC_W * NUM_SEC;

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    dir_ctl_t ab_c, ba_c;
    assign ab_c = '{ce_n: ce_ab_n[s], le_n: le_ab_n[s], oe_n: oe_ab_n[s]};
    assign ba_c = '{ce_n: ce_ba_n[s], le_n: le_ba_n[s], oe_n: oe_ba_n[s]};

    xcvr_section #(.W(SEC_W)) u_sec (
      .clk    (clk),
      .rst_n  (rst_n),
      .ab_ctl (ab_c),
      .ba_ctl (ba_c),
      .a_in   (a_in[s*SEC_W +: SEC_W]),
      .b_in   (b_in[s*SEC_W +: SEC_W]),
      .b_out  (b_out[s*SEC_W +: SEC_W]),
      .b_oe   (b_oe[s*SEC_W +: SEC_W]),
      .a_out  (a_out[s*SEC_W +: SEC_W]),
      .a_oe   (a_oe[s*SEC_W +: SEC_W]),
      .clash  (contention[s])
    );
  end

  if (TOT_W < 1) begin : g_bad
    initial $error("latched_bus_xcvr: empty datapath");
  end

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int SEC_W   = 18,
  parameter int NUM_SEC = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [SEC_W*NUM_SEC-1:0] a_in,
  input logic [SEC_W*NUM_SEC-1:0] b_in,
  input logic [NUM_SEC-1:0]       ce_ab_n,
  input logic [NUM_SEC-1:0]       le_ab_n,
  input logic [NUM_SEC-1:0]       oe_ab_n,
  input logic [NUM_SEC-1:0]       ce_ba_n,
  input logic [NUM_SEC-1:0]       le_ba_n,
  input logic [NUM_SEC-1:0]       oe_ba_n,
  input logic [SEC_W*NUM_SEC-1:0] b_out,
  input logic [SEC_W*NUM_SEC-1:0] b_oe,
  input logic [SEC_W*NUM_SEC-1:0] a_out,
  input logic [SEC_W*NUM_SEC-1:0] a_oe,
  input logic [NUM_SEC-1:0]       contention
);

  // R6
  b_undriven_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_out & ~b_oe) == '0);
  // R6
  a_undriven_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_out & ~a_oe) == '0);

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_chk
    // R5
    ab_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_ab_n[s] || oe_ab_n[s]) |-> (b_oe[s*SEC_W +: SEC_W] == '0));
    // R5
    ab_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_ab_n[s] && !oe_ab_n[s]) |-> (b_oe[s*SEC_W +: SEC_W] == '1));
    // R2
    ab_transp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_ab_n[s] && !le_ab_n[s] && !oe_ab_n[s])
        |-> (b_out[s*SEC_W +: SEC_W] == a_in[s*SEC_W +: SEC_W]));
    // R3
    ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_ab_n[s] && le_ab_n[s] && !oe_ab_n[s] &&
       $past(!ce_ab_n[s] && le_ab_n[s] && !oe_ab_n[s]))
        |-> $stable(b_out[s*SEC_W +: SEC_W]));
    // R7
    ba_transp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_ba_n[s] && !le_ba_n[s] && !oe_ba_n[s])
        |-> (a_out[s*SEC_W +: SEC_W] == b_in[s*SEC_W +: SEC_W]));
    // R7
    ba_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_ba_n[s] || oe_ba_n[s]) |-> (a_oe[s*SEC_W +: SEC_W] == '0));
    // R9
    clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      contention[s] == (a_oe[s*SEC_W] && b_oe[s*SEC_W]));
  end

endmodule

bind latched_bus_xcvr xcvr_checker #(.SEC_W(SEC_W), .NUM_SEC(NUM_SEC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .a_in       (a_in),
  .b_in       (b_in),
  .ce_ab_n    (ce_ab_n),
  .le_ab_n    (le_ab_n),
  .oe_ab_n    (oe_ab_n),
  .ce_ba_n    (ce_ba_n),
  .le_ba_n    (le_ba_n),
  .oe_ba_n    (oe_ba_n),
  .b_out      (b_out),
  .b_oe       (b_oe),
  .a_out      (a_out),
  .a_oe       (a_oe),
  .contention (contention)
);

// File: tb/test_latched_bus_xcvr.sv
module test_latched_bus_xcvr;

  localparam int W  = 4;
  localparam int NS = 2;
  localparam int T  = W * NS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [T-1:0]  a_in = '0, b_in = '0;
  logic [NS-1:0] ce_ab_n = '1, le_ab_n = '1, oe_ab_n = '1;
  logic [NS-1:0] ce_ba_n = '1, le_ba_n = '1, oe_ba_n = '1;
  logic [T-1:0]  b_out, b_oe, a_out, a_oe;
  logic [NS-1:0] contention;

  int n_cmp = 0;
  int n_bad = 0;

  logic [W-1:0] st_ab [NS];
  logic [W-1:0] st_ba [NS];

  always #5 clk = ~clk;

  latched_bus_xcvr #(.SEC_W(W), .NUM_SEC(NS)) i_latched_bus_xcvr (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .ce_ab_n(ce_ab_n), .le_ab_n(le_ab_n), .oe_ab_n(oe_ab_n),
    .ce_ba_n(ce_ba_n), .le_ba_n(le_ba_n), .oe_ba_n(oe_ba_n),
    .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe),
    .contention(contention)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every output of every section against the storage model
  task automatic check_all();
    for (int s = 0; s < NS; s++) begin
      logic ab_open, ab_drv, ba_open, ba_drv;
      logic [W-1:0] ea, eb, ain, bin;
      ain = a_in[s*W +: W];
      bin = b_in[s*W +: W];
      ab_open = !ce_ab_n[s] && !le_ab_n[s];
      ab_drv  = !ce_ab_n[s] && !oe_ab_n[s];
      ba_open = !ce_ba_n[s] && !le_ba_n[s];
      ba_drv  = !ce_ba_n[s] && !oe_ba_n[s];
      eb = ab_drv ? (ab_open ? ain : st_ab[s]) : '0;
      ea = ba_drv ? (ba_open ? bin : st_ba[s]) : '0;
      if (!ab_drv)     chk("R6 b_out undriven", int'(b_out[s*W +: W]), int'(eb));
      else if (ab_open) chk("R2 b_out transparent", int'(b_out[s*W +: W]), int'(eb));
      else             chk("R3 b_out held", int'(b_out[s*W +: W]), int'(eb));
      chk("R5 b_oe", int'(b_oe[s*W +: W]), ab_drv ? (1 << W) - 1 : 0);
      chk("R7 a_out", int'(a_out[s*W +: W]), int'(ea));
      chk("R7 a_oe", int'(a_oe[s*W +: W]), ba_drv ? (1 << W) - 1 : 0);
      chk("R9 contention", int'(contention[s]), int'(ab_drv && ba_drv));
    end
  endtask

  // One cycle: model captures at the rising edge, then back to the falling edge
  task automatic tick();
    @(posedge clk);
    for (int s = 0; s < NS; s++) begin
      if (!ce_ab_n[s] && !le_ab_n[s]) st_ab[s] = a_in[s*W +: W];
      if (!ce_ba_n[s] && !le_ba_n[s]) st_ba[s] = b_in[s*W +: W];
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin st_ab[s] = '0; st_ba[s] = '0; end
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: storage reads zero after reset, whatever the inputs
    a_in = 8'hA5; b_in = 8'h3C;
    ce_ab_n = '0; le_ab_n = '1; oe_ab_n = '0;
    ce_ba_n = '0; le_ba_n = '1; oe_ba_n = '0;
    #2;
    chk("R1 b_out after reset", int'(b_out), 0);
    chk("R1 a_out after reset", int'(a_out), 0);
    tick();

    // R4: chip select high blocks loading even with the gate low
    ce_ab_n[0] = 1'b0; le_ab_n[0] = 1'b0; a_in[3:0] = 4'h5;
    tick();
    le_ab_n[0] = 1'b1; tick();
    ce_ab_n[0] = 1'b1; le_ab_n[0] = 1'b0;
    for (int k = 0; k < 3; k++) begin a_in[3:0] = 4'(9 + k); tick(); end
    ce_ab_n[0] = 1'b0; le_ab_n[0] = 1'b1; oe_ab_n[0] = 1'b0; a_in[3:0] = 4'h3;
    #2;
    chk("R4 b_out keeps value from before chip select high", int'(b_out[3:0]), 5);
    tick();

    // R8: open section 0 only; section 1 must keep its stored value
    ce_ab_n = '0; oe_ab_n = '0; le_ab_n = 2'b10;
    a_in = 8'h6_9;
    tick();
    a_in = 8'hE_1;
    #2;
    chk("R8 section 0 transparent", int'(b_out[3:0]), 1);
    chk("R8 section 1 untouched", int'(b_out[7:4]), int'(st_ab[1]));
    tick();

    // Full sweep of both sections' control bits under two data patterns
    for (int rep = 0; rep < 2; rep++) begin
      for (int code = 0; code < 4096; code++) begin
        for (int s = 0; s < NS; s++) begin
          ce_ab_n[s] = code[6*s + 0];
          le_ab_n[s] = code[6*s + 1];
          oe_ab_n[s] = code[6*s + 2];
          ce_ba_n[s] = code[6*s + 3];
          le_ba_n[s] = code[6*s + 4];
          oe_ba_n[s] = code[6*s + 5];
        end
        a_in = 8'((code * 13 + rep * 7) ^ (rep * 8'h5A));
        b_in = 8'(~(code * 3 + rep * 11));
        #2;
        check_all();
        tick();
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule